// File: doc/BRIEF.md
# Clock Buffer Power-Up Sequencer

This block steps a clock fanout buffer from power-off to normal operation through four states. It holds the buffer outputs disabled until every condition for running has been met. It watches a supply-valid comparator flag, an input-clock-present flag, the qualified power-good level (low means power-down) and a PLL lock flag. All of these are sampled on a free-running timing clock.

After the supply becomes valid, the sequencer waits a fixed settling window whose length is a parameter in timing-clock cycles. The default is 50,000 cycles, which is 0.2 ms at 250 MHz and sits in the middle of the allowed 0.1 ms to 0.3 ms window. It then waits for an input clock and for power-down to be released. Next it enables the PLL, and it enables the outputs only once the PLL reports lock. If the input clock is lost or power-down is asserted while running, the sequencer falls back to waiting. Loss of supply returns it to power-off from any state.

A latency watchdog counts the cycles spent between leaving power-off and reaching normal operation, counting only while an input clock is present. It raises a sticky fault flag once the limit is reached. The default limit is 450,000 cycles, which is 1.8 ms at 250 MHz.

Top module: `pwrup_seq`

## Requirements
- R1: With `rst` high (synchronous, active high), the block goes on the next clock edge to `state` = 0, with `pll_en`, `out_en` and `lat_fault` all low.
- R2: The state encoding is 0 = off, 1 = settling, 2 = waiting, 3 = running. From off, the block moves to settling on the first edge at which `supply_ok` is high. From any state, `supply_ok` low moves the block to off on the next edge.
- R3: The settling state lasts exactly `SETTLE_CYC` cycles before the block moves to waiting. Leaving settling early, through supply loss, means a later entry waits the full `SETTLE_CYC` cycles again.
- R4: `pll_en` is a registered output. After an edge it is high exactly when the new state is waiting or running and `clk_present` and `pwr_good` were both high at that edge.
- R5: The block moves from waiting to running only on an edge at which `pll_en` is already high and `pll_locked`, `clk_present` and `pwr_good` are all high. `pll_locked` has no effect while the clock is absent or power-good is low.
- R6: `out_en` is high only in the running state. While `clk_present` is low, `out_en` stays low even if power is valid and power-good is high.
- R7: In the running state, `clk_present` low or `pwr_good` low moves the block back to waiting on the next edge, provided `supply_ok` stays high.
- R8: The latency counter is cleared in the off state. It advances on each edge at which the state is settling or waiting and `clk_present` is high. `lat_fault` rises on the edge where the count reaches `LAT_LIMIT`, stays high until the block has spent a cycle in off, and never rises while no clock is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running timing clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above its valid threshold |
| clk_present | input | 1 | Valid input clock detected |
| pwr_good | input | 1 | Power-good level; low requests power-down |
| pll_locked | input | 1 | PLL reports lock to the input clock |
| state | output | 2 | Current state: 0 off, 1 settling, 2 waiting, 3 running |
| pll_en | output | 1 | Enables the PLL |
| out_en | output | 1 | Enables the buffer outputs |
| lat_fault | output | 1 | Sticky flag: power-up latency limit exceeded |

## Verification
The state walk is driven with the inputs in several orders:
- lock present before the clock, which shows that lock alone does nothing;
- clock present while power-down is held, which separates the clock condition from the power-good condition;
- clock and power-good without lock, which separates PLL enable from output enable;
- each release condition removed in turn while running, which separates the two fallback causes from supply loss.

Directed runs measure the exact settling length, including the case where supply loss interrupts settling and the window must restart. They also check the exact edge on which the watchdog fires, that the fault stays set after running is reached and clears only through off, and that no fault builds up while the input clock is absent.

// File: rtl/pus_pkg.sv
package pus_pkg;
  typedef enum logic [1:0] {
    S_OFF    = 2'd0,
    S_SETTLE = 2'd1,
    S_WAIT   = 2'd2,
    S_RUN    = 2'd3
  } pus_state_e;
endpackage

// File: rtl/pus_settle_timer.sv
module pus_settle_timer #(
  parameter int unsigned SETTLE_CYC = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);

  // R3: every entry into settling starts the window from zero
  p_settle_from_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !$past(run)) |-> (cnt_q == '0));
endmodule

// File: rtl/pus_lat_wdog.sv
module pus_lat_wdog #(
  parameter int unsigned LAT_LIMIT = 450000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic count_en,
  output logic fault
);
  localparam int unsigned CW = $clog2(LAT_LIMIT + 1);
  localparam logic [CW-1:0] LIM    = CW'(LAT_LIMIT);
  localparam logic [CW-1:0] LIM_M1 = CW'(LAT_LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          fault_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (count_en && cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LIM_M1) fault_q <= 1'b1;
    end
  end

  assign fault = fault_q;

  // R8: fault is sticky until cleared, and a clear always drops it
  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (fault_q && !clear) |=> fault_q);
  p_fault_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clear |=> !fault_q);
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pus_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 50000,
  parameter int unsigned LAT_LIMIT  = 450000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok,
  input  logic       clk_present,
  input  logic       pwr_good,
  input  logic       pll_locked,
  output logic [1:0] state,
  output logic       pll_en,
  output logic       out_en,
  output logic       lat_fault
);
  pus_state_e state_q, nxt;
  logic       settle_done;
  logic       pll_en_q, out_en_q;
  logic       wd_clear, wd_count;
  logic       ready;

  assign ready = clk_present && pwr_good;

  pus_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk  (clk),
    .rst  (rst),
    .run  (state_q == S_SETTLE),
    .done (settle_done)
  );

  assign wd_clear = (state_q == S_OFF);
  assign wd_count = ((state_q == S_SETTLE) || (state_q == S_WAIT)) && clk_present;

  pus_lat_wdog #(.LAT_LIMIT(LAT_LIMIT)) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .clear    (wd_clear),
    .count_en (wd_count),
    .fault    (lat_fault)
  );

  always_comb begin
    nxt = state_q;
    if (!supply_ok) nxt = S_OFF;
    else begin
      case (state_q)
        S_OFF:    nxt = S_SETTLE;
        S_SETTLE: if (settle_done) nxt = S_WAIT;
        S_WAIT:   if (ready && pll_en_q && pll_locked) nxt = S_RUN;
        S_RUN:    if (!ready) nxt = S_WAIT;
        default:  nxt = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_OFF;
      pll_en_q <= 1'b0;
      out_en_q <= 1'b0;
    end else begin
      state_q  <= nxt;
      pll_en_q <= ((nxt == S_WAIT) || (nxt == S_RUN)) && ready;
      out_en_q <= (nxt == S_RUN);
    end
  end

  assign state  = state_q;
  assign pll_en = pll_en_q;
  assign out_en = out_en_q;

  // R2: supply loss forces off on the next edge
  p_supply_loss_off_r2: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (state_q == S_OFF));
  // R5: entering running requires lock with the PLL already enabled
  p_run_needs_lock_r5: assert property (@(posedge clk) disable iff (rst)
    ((state_q == S_RUN) && ($past(state_q) != S_RUN)) |-> $past(pll_locked && pll_en_q));
  // R6: no input clock means outputs stay disabled
  p_no_clk_no_out_r6: assert property (@(posedge clk) disable iff (rst)
    !clk_present |=> !out_en_q);
  // R6: outputs are never enabled without the PLL enabled
  p_out_implies_pll_r6: assert property (@(posedge clk) disable iff (rst)
    out_en_q |-> pll_en_q);
  // R7: losing clock or power-good while running falls back to waiting
  p_run_fallback_r7: assert property (@(posedge clk) disable iff (rst)
    ((state_q == S_RUN) && supply_ok && !ready) |=> (state_q == S_WAIT));
endmodule

// File: tb/tb_pwrup_seq.sv
`timescale 1ns/1ps
module tb_pwrup_seq;
  localparam int unsigned SET = 8;
  localparam int unsigned LAT = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_ok = 1'b0, c_ok = 1'b0, pg = 1'b0, lk = 1'b0;
  logic [1:0] st;
  logic pll, oen, flt;
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwrup_seq #(.SETTLE_CYC(SET), .LAT_LIMIT(LAT)) dut (
    .clk(clk), .rst(rst), .supply_ok(s_ok), .clk_present(c_ok),
    .pwr_good(pg), .pll_locked(lk), .state(st), .pll_en(pll),
    .out_en(oen), .lat_fault(flt)
  );

  // fields: [12]supply [11]clock [10]pgood [9]lock [8:5]edges [4:3]state [2]pll [1]out [0]fault
  localparam int NV = 15;
  localparam logic [12:0] VEC [NV] = '{
    {4'b0000, 4'd2, 2'd0, 3'b000},
    {4'b1000, 4'd1, 2'd1, 3'b000},
    {4'b1000, 4'd7, 2'd1, 3'b000},
    {4'b1000, 4'd1, 2'd2, 3'b000},
    {4'b1011, 4'd3, 2'd2, 3'b000},
    {4'b1101, 4'd3, 2'd2, 3'b000},
    {4'b1110, 4'd1, 2'd2, 3'b100},
    {4'b1110, 4'd3, 2'd2, 3'b100},
    {4'b1111, 4'd1, 2'd3, 3'b110},
    {4'b1011, 4'd1, 2'd2, 3'b000},
    {4'b1111, 4'd1, 2'd2, 3'b100},
    {4'b1111, 4'd1, 2'd3, 3'b110},
    {4'b1101, 4'd1, 2'd2, 3'b000},
    {4'b1111, 4'd2, 2'd3, 3'b110},
    {4'b0111, 4'd1, 2'd0, 3'b000}
  };

  task automatic setin(input logic s, input logic c, input logic g, input logic l);
    @(negedge clk);
    s_ok = s; c_ok = c; pg = g; lk = l;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [1:0] es, input logic ep,
                       input logic eo, input logic ef);
    checks++;
    if (st !== es || pll !== ep || oen !== eo || flt !== ef) begin
      fails++;
      $display("FAIL %s: got state=%0d pll=%0b out=%0b fault=%0b, expected state=%0d pll=%0b out=%0b fault=%0b",
               req, st, pll, oen, flt, es, ep, eo, ef);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; s_ok = 0; c_ok = 0; pg = 0; lk = 0;
    tick(2);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    tick(3);
    check("R1 reset state", 2'd0, 0, 0, 0);
    @(negedge clk);
    rst = 1'b0;

    // table walk covers R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      v = VEC[i];
      setin(v[12], v[11], v[10], v[9]);
      tick(int'(v[8:5]));
      check($sformatf("R2/R3/R4/R5/R6/R7 table step %0d", i), v[4:3], v[2], v[1], v[0]);
    end

    // R1: reset from running
    do_reset();
    setin(1, 1, 1, 1);
    tick(SET + 3);
    check("R5 reach running", 2'd3, 1, 1, 0);
    @(negedge clk); rst = 1'b1;
    tick(1);
    check("R1 reset while running", 2'd0, 0, 0, 0);

    // R3: settling interrupted by supply loss restarts the full window
    do_reset();
    setin(1, 0, 0, 0);
    tick(1);
    check("R3 enter settling", 2'd1, 0, 0, 0);
    tick(3);
    setin(0, 0, 0, 0);
    tick(1);
    check("R2 supply loss in settling", 2'd0, 0, 0, 0);
    setin(1, 0, 0, 0);
    tick(1);
    tick(SET - 1);
    check("R3 restarted window still settling", 2'd1, 0, 0, 0);
    tick(1);
    check("R3 restarted window ends", 2'd2, 0, 0, 0);

    // R8: watchdog fires at exactly LAT counted cycles
    do_reset();
    setin(1, 1, 1, 0);
    tick(1);
    tick(LAT - 1);
    check("R8 fault not yet", 2'd2, 1, 0, 0);
    tick(1);
    check("R8 fault at limit", 2'd2, 1, 0, 1);
    setin(1, 1, 1, 1);
    tick(1);
    check("R8 fault sticky into running", 2'd3, 1, 1, 1);
    setin(0, 1, 1, 1);
    tick(1);
    check("R8 off state reached", 2'd0, 0, 0, 1);
    tick(1);
    check("R8 fault cleared by off", 2'd0, 0, 0, 0);

    // R6/R8: no input clock -> outputs disabled and no fault
    do_reset();
    setin(1, 0, 1, 1);
    tick(LAT + 20);
    check("R6 no clock keeps outputs off", 2'd2, 0, 0, 0);
    check("R8 no clock no fault", 2'd2, 0, 0, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule